// File: doc/BRIEF.md
# Byte-Link Control Word Endpoint

This block terminates an 8-bit parallel inter-processor link on the control side of a converter board. It starts out as a receiver, packs four link bytes into a 32-bit control word, and uses the top four bits of each word to select what to do with the remaining 28 bits: store them in one of four control registers, reset the whole endpoint, or start a serial load of the clock-synthesizer settings.

After any reset, hardware or commanded, the first word that arrives is a dummy. Its value is ignored and it is never stored. In answer, the endpoint asks its peer for the link token. Once the token is granted it sends one identification word, `0xFF364F` followed by the major and minor firmware version nibbles. It then gives the token back and listens again. A host uses this exchange to confirm that the board is alive and to learn which firmware it runs.

Top module: `lep_top`

## Requirements
- R1: After `rst_n` is low on a clock edge, `rx_rdy_o` is 1, `tok_req_o`, `tx_stb_o`, `gres_o` and `load_start_o` are 0, and every register in `regs_o` is 0.
- R2: A byte is taken on each rising clock edge where `rx_stb_i` and `rx_rdy_o` are both 1. Four taken bytes form one word, with the first byte as bits [7:0] and the fourth byte as bits [31:24].
- R3: The first word after any reset is not stored. The endpoint then raises `tok_req_o` and waits for `tok_gnt_i`. It then presents the identification word `{8'hFF,12'h364,4'hF,major,minor}` on `tx_dat_o`, one byte at a time, least significant byte first. Each byte is held with `tx_stb_o` high until a clock edge where `tx_ack_i` is 1.
- R4: After the fourth byte is acknowledged, `tok_req_o` falls. Once `tok_gnt_i` is low the endpoint returns to receiving with `rx_rdy_o` at 1. Later words produce no further reply.
- R5: For a word whose bits [31:28] are 0 to 3, bits [27:0] are written to that register. Register n appears on `regs_o[28n+27:28n]` from the edge after the word completes.
- R6: A word with bits [31:28] equal to 0xD clears all registers and pulses `gres_o` high for exactly one cycle. The next word is then treated as a dummy again, as in R3.
- R7: A word with bits [31:28] equal to 0xF leaves every register unchanged. If `load_busy_i` is 0, it pulses `load_start_o` high for exactly one cycle.
- R8: A 0xF word that completes while `load_busy_i` is 1 produces no `load_start_o` pulse.
- R9: Words with bits [31:28] from 4 to 0xC, or equal to 0xE, change no register and produce no pulse.
- R10: `rx_rdy_o` is 0 while `tok_req_o` is 1, and bytes strobed during that time are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dat_i | input | 8 | Received link byte |
| rx_stb_i | input | 1 | Peer offers a byte |
| rx_rdy_o | output | 1 | Endpoint accepts bytes this cycle |
| tok_req_o | output | 1 | Request for the link token (transmit direction) |
| tok_gnt_i | input | 1 | Peer grants the token |
| tx_dat_o | output | 8 | Transmitted reply byte |
| tx_stb_o | output | 1 | Reply byte valid |
| tx_ack_i | input | 1 | Peer took the reply byte |
| load_busy_i | input | 1 | Serial loader still busy |
| regs_o | output | 112 | Four 28-bit control registers, register 0 in the low bits |
| gres_o | output | 1 | One-cycle global reset pulse |
| load_start_o | output | 1 | One-cycle serial load start pulse |

## Verification
The bench uses the default build: an 8-bit link, 32-bit words, four registers, and version 1.2, so the reply is 0xFF364F12. With a 4-bit address field, the bench can send every one of the 16 possible addresses. That covers each store, both commands and all ignored codes, and it compares the whole register file after each word. The two reset handshakes and the busy and idle cases of the loader are each run one after the other.

// File: rtl/lep_pkg.sv
// Shared types for the link control endpoint.
// Assumes: used only by the lep_* modules.
package lep_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_REQ  = 2'd1,
        TX_SEND = 2'd2,
        TX_REL  = 2'd3
    } lep_tx_e;
endpackage

// File: rtl/lep_assembler.sv
// Packs link bytes into words, least significant byte first.
// Assumes: WW is a whole multiple of DW; clr_i restarts the byte count.
module lep_assembler #(
    parameter int DW = 8,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          byte_vld_i,
    input  logic [DW-1:0] byte_i,
    output logic          word_vld_o,
    output logic [WW-1:0] word_o
);
    localparam int NB = WW / DW;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [CW-1:0] LAST = CW'(NB - 1);

    logic [CW-1:0] cnt;

    // Place each byte in its lane and flag the word when the last lane fills.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt        <= '0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
        end else begin
            word_vld_o <= 1'b0;
            if (byte_vld_i) begin
                word_o[cnt*DW +: DW] <= byte_i;
                if (cnt == LAST) begin
                    cnt        <= '0;
                    word_vld_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o); // R2
endmodule

// File: rtl/lep_reply_tx.sv
// Turns the link around to send one word, then returns the token.
// Assumes: word_i is stable while busy_o is high; the peer raises tok_gnt_i
// only after tok_req_o and drops it after tok_req_o falls.
module lep_reply_tx #(
    parameter int DW = 8,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [WW-1:0] word_i,
    output logic          tok_req_o,
    input  logic          tok_gnt_i,
    output logic          tx_stb_o,
    output logic [DW-1:0] tx_dat_o,
    input  logic          tx_ack_i,
    output logic          busy_o
);
    import lep_pkg::*;
    localparam int NB = WW / DW;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [CW-1:0] LAST = CW'(NB - 1);

    lep_tx_e       st;
    logic [CW-1:0] idx;

    // Walk request, send and release phases of the token exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TX_IDLE;
            idx <= '0;
        end else begin
            case (st)
                TX_IDLE: if (start_i) st <= TX_REQ;
                TX_REQ: if (tok_gnt_i) begin
                    st  <= TX_SEND;
                    idx <= '0;
                end
                TX_SEND: if (tx_ack_i) begin
                    if (idx == LAST) st <= TX_REL;
                    else idx <= idx + 1'b1;
                end
                TX_REL: if (!tok_gnt_i) st <= TX_IDLE;
                default: st <= TX_IDLE;
            endcase
        end
    end

    // Drive the token request and the current reply byte.
    always_comb begin
        tok_req_o = (st == TX_REQ) || (st == TX_SEND);
        tx_stb_o  = (st == TX_SEND);
        tx_dat_o  = word_i[idx*DW +: DW];
        busy_o    = (st != TX_IDLE);
    end

    AST_REQ_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tok_req_o) |-> $past(tx_stb_o && tx_ack_i)); // R4
    AST_STB_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |-> tok_req_o); // R3
endmodule

// File: rtl/lep_regfile.sv
// Bank of control registers written by index and cleared on command.
// Assumes: one write at most per cycle; clr_i wins over a write.
module lep_regfile #(
    parameter int NREG = 4,
    parameter int PW   = 28,
    parameter int RIW  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               we_i,
    input  logic [RIW-1:0]     idx_i,
    input  logic [PW-1:0]      data_i,
    output logic [NREG*PW-1:0] regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold one register; load it when addressed, zero it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) regs_o[g*PW +: PW] <= '0;
            else if (we_i && idx_i == RIW'(g)) regs_o[g*PW +: PW] <= data_i;
        end
    end

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (regs_o == '0)); // R6
endmodule

// File: rtl/lep_top.sv
// Link endpoint: receives control words, answers the post-reset dummy word
// with an identification word, stores registers and issues command pulses.
// Assumes: address in the top AW bits; commands CMD_RST and CMD_LOAD.
module lep_top #(
    parameter int          DW       = 8,
    parameter int          WW       = 32,
    parameter int          AW       = 4,
    parameter int          NREG     = 4,
    parameter int          VER_MAJ  = 1,
    parameter int          VER_MIN  = 2,
    parameter logic [3:0]  CMD_RST  = 4'hD,
    parameter logic [3:0]  CMD_LOAD = 4'hF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DW-1:0]           rx_dat_i,
    input  logic                    rx_stb_i,
    output logic                    rx_rdy_o,
    output logic                    tok_req_o,
    input  logic                    tok_gnt_i,
    output logic [DW-1:0]           tx_dat_o,
    output logic                    tx_stb_o,
    input  logic                    tx_ack_i,
    input  logic                    load_busy_i,
    output logic [NREG*(WW-AW)-1:0] regs_o,
    output logic                    gres_o,
    output logic                    load_start_o
);
    localparam int PW  = WW - AW;
    localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [WW-1:0] ID_WORD =
        WW'({8'hFF, 12'h364, 4'hF, 4'(VER_MAJ), 4'(VER_MIN)});

    logic          wvld, armed, tx_busy, soft_clr, reg_we, is_load;
    logic [WW-1:0] word;
    logic [AW-1:0] addr;

    // Accept bytes only while listening and no finished word is pending.
    assign rx_rdy_o = !tx_busy && !wvld;
    assign addr     = word[WW-1 -: AW];
    assign soft_clr = wvld && !armed && (addr == AW'(CMD_RST));
    assign reg_we   = wvld && !armed && (32'(addr) < NREG);
    assign is_load  = wvld && !armed && (addr == AW'(CMD_LOAD));

    lep_assembler #(.DW(DW), .WW(WW)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr_i(soft_clr),
        .byte_vld_i(rx_stb_i && rx_rdy_o), .byte_i(rx_dat_i),
        .word_vld_o(wvld), .word_o(word)
    );

    lep_reply_tx #(.DW(DW), .WW(WW)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(wvld && armed), .word_i(ID_WORD),
        .tok_req_o(tok_req_o), .tok_gnt_i(tok_gnt_i),
        .tx_stb_o(tx_stb_o), .tx_dat_o(tx_dat_o), .tx_ack_i(tx_ack_i),
        .busy_o(tx_busy)
    );

    lep_regfile #(.NREG(NREG), .PW(PW), .RIW(RIW)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr_i(soft_clr), .we_i(reg_we),
        .idx_i(addr[RIW-1:0]), .data_i(word[PW-1:0]), .regs_o(regs_o)
    );

    // Track the dummy-word handshake and register the command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed        <= 1'b1;
            gres_o       <= 1'b0;
            load_start_o <= 1'b0;
        end else begin
            gres_o       <= soft_clr;
            load_start_o <= is_load && !load_busy_i;
            if (wvld && armed) armed <= 1'b0;
            else if (soft_clr) armed <= 1'b1;
        end
    end

    AST_GRES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        gres_o |=> !gres_o); // R6
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_start_o |=> !load_start_o); // R7
    AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_start_o |-> !$past(load_busy_i)); // R8
    AST_NO_RX_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tok_req_o |-> !rx_rdy_o); // R10
endmodule

// File: tb/lep_top_test.sv
// Self-checking bench: address sweep, both handshakes, loader busy cases.
module lep_top_test;
    localparam int NREG = 4;
    localparam int PW   = 28;
    localparam logic [31:0] ID_EXP = 32'hFF364F12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [7:0]           rx_dat_i = '0;
    logic                 rx_stb_i = 1'b0;
    logic                 rx_rdy_o, tok_req_o, tx_stb_o, gres_o, load_start_o;
    logic                 tok_gnt_i = 1'b0;
    logic                 tx_ack_i = 1'b0;
    logic                 load_busy_i = 1'b0;
    logic [7:0]           tx_dat_o;
    logic [NREG*PW-1:0]   regs_o;

    int checks = 0;
    int fails  = 0;
    logic [PW-1:0] model [NREG];

    always #10 clk = ~clk;

    lep_top uut (
        .clk(clk), .rst_n(rst_n), .rx_dat_i(rx_dat_i), .rx_stb_i(rx_stb_i),
        .rx_rdy_o(rx_rdy_o), .tok_req_o(tok_req_o), .tok_gnt_i(tok_gnt_i),
        .tx_dat_o(tx_dat_o), .tx_stb_o(tx_stb_o), .tx_ack_i(tx_ack_i),
        .load_busy_i(load_busy_i), .regs_o(regs_o), .gres_o(gres_o),
        .load_start_o(load_start_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(regs_o[i*PW +: PW] == model[i], tag,
                64'(regs_o[i*PW +: PW]), 64'(model[i]));
    endtask

    // Sends four bytes LSB first; returns in the cycle the word is complete.
    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_stb_i = 1'b1;
            rx_dat_i = w[i*8 +: 8];
        end
        @(negedge clk);
        rx_stb_i = 1'b0;
    endtask

    // Serves the token exchange, offering junk bytes before granting (R10).
    task automatic serve_reply(output logic [31:0] got);
        int n = 0;
        got = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_stb_i = 1'b1;
            rx_dat_i = 8'hEE;
        end
        @(negedge clk);
        rx_stb_i  = 1'b0;
        tok_gnt_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_stb_o && n < 4) begin
                got[n*8 +: 8] = tx_dat_o;
                n++;
                tx_ack_i = 1'b1;
            end else begin
                tx_ack_i = 1'b0;
            end
            if (!tok_req_o && n == 4) break;
        end
        tok_gnt_i = 1'b0;
        tx_ack_i  = 1'b0;
        @(negedge clk);
    endtask

    task automatic handshake(input logic [31:0] dummy, input string tag);
        logic [31:0] got;
        send_word(dummy);
        @(negedge clk);
        chk(tok_req_o == 1'b1, {tag, " token requested"}, 64'(tok_req_o), 1);
        chk(rx_rdy_o == 1'b0, "R10 rx blocked while turned", 64'(rx_rdy_o), 0);
        chk_regs({tag, " dummy not stored"});
        serve_reply(got);
        chk(got == ID_EXP, {tag, " id word"}, 64'(got), 64'(ID_EXP));
        chk(tok_req_o == 1'b0 && rx_rdy_o == 1'b1, "R4 back to receive",
            64'({tok_req_o, rx_rdy_o}), 64'(2'b01));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_rdy_o && !tok_req_o && !tx_stb_o && !gres_o && !load_start_o,
            "R1 reset outputs",
            64'({rx_rdy_o, tok_req_o, tx_stb_o, gres_o, load_start_o}), 64'h10);
        chk_regs("R1 regs zero");

        handshake(32'h0123_4567, "R3");

        // R2 R5 R7 R9 sweep over every address code except the reset command
        for (int a = 0; a < 16; a++) begin
            logic [PW-1:0] p;
            if (a == 13) continue;
            p = PW'(a * 32'h0135_79BD + 32'h0A5C_3E1);
            send_word({4'(a), p});
            @(negedge clk);
            if (a < NREG) model[a] = p;
            chk_regs(a < NREG ? "R5 R2 store" : "R9 ignored code");
            chk(load_start_o == (a == 15), "R7 load pulse", 64'(load_start_o),
                64'(a == 15));
            chk(!gres_o && !tok_req_o, "R4 no reply, no reset",
                64'({gres_o, tok_req_o}), 0);
            @(negedge clk);
            chk(!load_start_o, "R7 pulse one cycle", 64'(load_start_o), 0);
        end

        // R8 load blocked while busy, then accepted
        load_busy_i = 1'b1;
        send_word({4'hF, 28'h0});
        @(negedge clk);
        chk(!load_start_o, "R8 busy load ignored", 64'(load_start_o), 0);
        load_busy_i = 1'b0;
        send_word({4'hF, 28'h0});
        @(negedge clk);
        chk(load_start_o, "R7 idle load starts", 64'(load_start_o), 1);
        chk_regs("R7 regs kept");

        // R6 global reset command
        send_word({4'hD, 28'hFFF_FFFF});
        @(negedge clk);
        for (int i = 0; i < NREG; i++) model[i] = '0;
        chk(gres_o, "R6 gres pulse", 64'(gres_o), 1);
        chk_regs("R6 regs cleared");
        @(negedge clk);
        chk(!gres_o, "R6 gres one cycle", 64'(gres_o), 0);
        handshake({4'h1, 28'h123_4567}, "R6");
        send_word({4'h2, 28'hBEE_F00D});
        @(negedge clk);
        model[2] = 28'hBEE_F00D;
        chk_regs("R5 store after new handshake");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule